// File: doc/BRIEF.md
# Processor Status Flag Register

This block is the eight-bit status word of a small microcontroller core. It keeps four arithmetic flags (carry, half carry, zero, overflow) and two system flags (power-down and watchdog time-out). The arithmetic flags are loaded by the ALU under a separate enable for each flag, or by an ordinary data-memory write to the register's address. The system flags are read-only to software. Only four one-cycle event strobes move them: power-up reset, watchdog clear, halt and watchdog time-out.

The current value is always visible on the read port. All updates take effect at the next rising clock edge. Power-up is the asynchronous active-low reset input. It clears the register at once, and its release is synchronised to the clock inside the block.

Top module: `status_flags_reg`

## Requirements
- R1: While power-up reset is asserted, the read port shows 0x00, which means all six flags are clear.
- R2: Bit layout: carry is bit 0, half carry is bit 1, zero is bit 2, overflow is bit 3, power-down is bit 4 and time-out is bit 5. Bits 7 and 6 always read 0, even after a write of ones.
- R3: A write to address 0x0A with no ALU enable loads bits 3..0 of the write data into the arithmetic flags on the next edge.
- R4: A write to any address other than 0x0A leaves the register unchanged.
- R5: A register write never changes bit 4 or bit 5.
- R6: Each ALU flag whose enable is high takes the ALU value. Each flag whose enable is low keeps its value when no write hits.
- R7: When an ALU update and a register write hit in the same cycle, an enabled flag takes the ALU value. A flag that is not enabled takes the write data.
- R8: A halt strobe sets power-down and clears time-out.
- R9: A watchdog-clear strobe clears both power-down and time-out.
- R10: A time-out strobe sets time-out and leaves power-down unchanged.
- R11: A time-out strobe in the same cycle as a watchdog clear or a halt leaves time-out set. Power-down follows the other strobe.
- R12: A halt in the same cycle as a watchdog clear leaves power-down set and time-out clear.
- R13: With no strobe, no ALU enable and no write hit, the register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-up reset, asynchronous, active low |
| alu_flags_i | input | 4 | ALU flag values {ov, z, ac, c} |
| alu_en_i | input | 4 | Update enable for each ALU flag, same bit order |
| wr_en_i | input | 1 | Data-memory write strobe |
| wr_addr_i | input | 8 | Data-memory write address |
| wr_data_i | input | 8 | Data-memory write data |
| wdt_clr_i | input | 1 | Watchdog-clear instruction strobe |
| halt_i | input | 1 | Halt instruction strobe |
| wdt_tmo_i | input | 1 | Watchdog time-out strobe |
| rd_data_o | output | 8 | Current status word |

## Verification
On every cycle, the assertions check the following rules: the unused bits read zero, writes leave the system flags alone, each strobe moves the system flags in its fixed pattern, enabled ALU flags load their values, write data reaches the flags that are not enabled, and the register holds when idle. The bench scenarios are needed to show three things the assertions cannot: the immediate effect of asserting power-up reset, the delayed resumption of updates after reset is released, and a sequence of mixed events in which the register accumulates the exact word a software reader would see.

// File: rtl/status_pkg.sv
package status_pkg;
  localparam int DATA_W      = 8;
  localparam int ADDR_W      = 8;
  localparam int N_ARITH     = 4;
  localparam int C_POS       = 0;
  localparam int AC_POS      = 1;
  localparam int Z_POS       = 2;
  localparam int OV_POS      = 3;
  localparam int PDF_POS     = 4;
  localparam int TO_POS      = 5;
  localparam int USED_BITS   = 6;
  localparam logic [ADDR_W-1:0] STATUS_ADDR = 8'h0A;
endpackage

// File: rtl/sr_rst_sync.sv
module sr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/sr_arith_flags.sv
module sr_arith_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] alu_val,
  input  logic [N-1:0] alu_en,
  input  logic         wr_hit,
  input  logic [N-1:0] wr_val,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] flags_q;
  logic [N-1:0] flags_d;
  logic [N-1:0] load_en;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_comb begin
      load_en[i] = alu_en[i] | wr_hit;
      if (alu_en[i])   flags_d[i] = alu_val[i];
      else if (wr_hit) flags_d[i] = wr_val[i];
      else             flags_d[i] = flags_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flags_q[i] <= 1'b0;
      else if (load_en[i]) flags_q[i] <= flags_d[i];
    end
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/sr_sys_flags.sv
module sr_sys_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic wdt_clr,
  input  logic halt,
  input  logic wdt_tmo,
  output logic pdf_o,
  output logic to_o
);
  logic pdf_q, pdf_d, pdf_en;
  logic to_q, to_d, to_en;

  always_comb begin
    pdf_en = halt | wdt_clr;
    pdf_d  = halt;
    to_en  = wdt_tmo | wdt_clr | halt;
    to_d   = wdt_tmo;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pdf_q <= 1'b0;
      to_q  <= 1'b0;
    end else begin
      if (pdf_en) pdf_q <= pdf_d;
      if (to_en)  to_q  <= to_d;
    end
  end

  assign pdf_o = pdf_q;
  assign to_o  = to_q;
endmodule

// File: rtl/status_flags_reg.sv
module status_flags_reg
  import status_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_ARITH-1:0] alu_flags_i,
  input  logic [N_ARITH-1:0] alu_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wdt_clr_i,
  input  logic              halt_i,
  input  logic              wdt_tmo_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic               rst_q_n;
  logic               wr_hit;
  logic [N_ARITH-1:0] arith;
  logic               pdf;
  logic               to_flag;

  sr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_q_n)
  );

  assign wr_hit = wr_en_i && (wr_addr_i == STATUS_ADDR);

  sr_arith_flags #(.N(N_ARITH)) u_arith (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .alu_val (alu_flags_i),
    .alu_en  (alu_en_i),
    .wr_hit  (wr_hit),
    .wr_val  (wr_data_i[N_ARITH-1:0]),
    .flags_o (arith)
  );

  sr_sys_flags u_sys (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .wdt_clr (wdt_clr_i),
    .halt    (halt_i),
    .wdt_tmo (wdt_tmo_i),
    .pdf_o   (pdf),
    .to_o    (to_flag)
  );

  always_comb begin
    rd_data_o                  = '0;
    rd_data_o[OV_POS:C_POS]    = arith;
    rd_data_o[PDF_POS]         = pdf;
    rd_data_o[TO_POS]          = to_flag;
  end
endmodule

// File: rtl/status_flags_chk.sv
module status_flags_chk
  import status_pkg::*;
(
  input logic              clk,
  input logic              rst_q_n,
  input logic [N_ARITH-1:0] alu_flags_i,
  input logic [N_ARITH-1:0] alu_en_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              wdt_clr_i,
  input logic              halt_i,
  input logic              wdt_tmo_i,
  input logic [DATA_W-1:0] rd_data_o
);
  logic hit_c;
  logic quiet_c;
  assign hit_c   = wr_en_i && (wr_addr_i == STATUS_ADDR);
  assign quiet_c = !hit_c && (alu_en_i == '0) && !wdt_clr_i && !halt_i && !wdt_tmo_i;

  // R2
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    rd_data_o[7:6] == 2'b00);

  // R5
  sys_write_protect_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (hit_c && !wdt_clr_i && !halt_i && !wdt_tmo_i) |=> $stable(rd_data_o[TO_POS:PDF_POS]));

  // R8
  halt_pattern_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (halt_i && !wdt_tmo_i) |=> (rd_data_o[PDF_POS] && !rd_data_o[TO_POS]));

  // R9
  clear_pattern_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wdt_clr_i && !halt_i && !wdt_tmo_i) |=> (rd_data_o[TO_POS:PDF_POS] == 2'b00));

  // R11
  timeout_wins_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    wdt_tmo_i |=> rd_data_o[TO_POS]);

  // R6
  alu_load_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (alu_en_i != '0) |=> ((rd_data_o[3:0] & $past(alu_en_i)) == ($past(alu_flags_i) & $past(alu_en_i))));

  // R7
  write_fill_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    hit_c |=> ((rd_data_o[3:0] & ~$past(alu_en_i)) == ($past(wr_data_i[3:0]) & ~$past(alu_en_i))));

  // R13
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    quiet_c |=> $stable(rd_data_o));
endmodule

bind status_flags_reg status_flags_chk u_chk (
  .clk         (clk),
  .rst_q_n     (rst_q_n),
  .alu_flags_i (alu_flags_i),
  .alu_en_i    (alu_en_i),
  .wr_en_i     (wr_en_i),
  .wr_addr_i   (wr_addr_i),
  .wr_data_i   (wr_data_i),
  .wdt_clr_i   (wdt_clr_i),
  .halt_i      (halt_i),
  .wdt_tmo_i   (wdt_tmo_i),
  .rd_data_o   (rd_data_o)
);

// File: tb/sim_status_flags_reg.sv
`timescale 1ns/1ps
module sim_status_flags_reg;
  logic       clk;
  logic       rst_n;
  logic [3:0] alu_flags;
  logic [3:0] alu_en;
  logic       wr_en;
  logic [7:0] wr_addr;
  logic [7:0] wr_data;
  logic       wdt_clr;
  logic       halt;
  logic       wdt_tmo;
  logic [7:0] rd_data;

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] model;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  bit         done = 0;

  status_flags_reg u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .alu_flags_i (alu_flags),
    .alu_en_i    (alu_en),
    .wr_en_i     (wr_en),
    .wr_addr_i   (wr_addr),
    .wr_data_i   (wr_data),
    .wdt_clr_i   (wdt_clr),
    .halt_i      (halt),
    .wdt_tmo_i   (wdt_tmo),
    .rd_data_o   (rd_data)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: rd_data=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] af, input logic [3:0] ae, input logic we,
                       input logic [7:0] addr, input logic [7:0] data,
                       input logic clr, input logic hlt, input logic tmo, input string tag);
    logic hit;
    @(negedge clk);
    alu_flags = af; alu_en = ae; wr_en = we; wr_addr = addr; wr_data = data;
    wdt_clr = clr; halt = hlt; wdt_tmo = tmo;
    hit = we && (addr == 8'h0A);
    for (int i = 0; i < 4; i++) begin
      if (ae[i])    model[i] = af[i];
      else if (hit) model[i] = data[i];
    end
    if (hlt)      model[4] = 1'b1;
    else if (clr) model[4] = 1'b0;
    if (tmo)             model[5] = 1'b1;
    else if (clr || hlt) model[5] = 1'b0;
    exp_q.push_back(model);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input string tag);
    drive(4'h0, 4'h0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, tag);
  endtask

  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(rd_data, e, t);
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(rd_data, 8'h00, "R1 reset clears flags");
    model = 8'h00;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    alu_flags = '0; alu_en = '0; wr_en = 0; wr_addr = '0; wr_data = '0;
    wdt_clr = 0; halt = 0; wdt_tmo = 0;
    model = 8'h00;
    #12;
    check(rd_data, 8'h00, "R1 power-up value");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    drive(4'h0, 4'h0, 1'b1, 8'h0A, 8'hFF, 0, 0, 0, "R3 R2 R5 write ones");
    drive(4'h0, 4'h0, 1'b1, 8'h0B, 8'h00, 0, 0, 0, "R4 other address");
    drive(4'h0, 4'h0, 1'b0, 8'h00, 8'h00, 0, 1, 0, "R8 halt");
    drive(4'h0, 4'h0, 1'b1, 8'h0A, 8'h00, 0, 0, 0, "R5 write keeps PDF");
    drive(4'h0, 4'h0, 1'b0, 8'h00, 8'h00, 0, 0, 1, "R10 timeout");
    drive(4'h0, 4'h0, 1'b1, 8'h0A, 8'hC0, 0, 0, 0, "R5 R2 write keeps TO");
    idle("R13 hold");
    drive(4'h0, 4'h0, 1'b0, 8'h00, 8'h00, 1, 0, 0, "R9 watchdog clear");
    drive(4'hF, 4'h5, 1'b0, 8'h00, 8'h00, 0, 0, 0, "R6 partial ALU");
    drive(4'h0, 4'h2, 1'b1, 8'h0A, 8'h0F, 0, 0, 0, "R7 ALU beats write");
    drive(4'h0, 4'h0, 1'b0, 8'h00, 8'h00, 1, 0, 1, "R11 timeout with clear");
    drive(4'h0, 4'h0, 1'b0, 8'h00, 8'h00, 0, 1, 0, "R8 halt clears TO");
    drive(4'h0, 4'h0, 1'b0, 8'h00, 8'h00, 0, 1, 1, "R11 timeout with halt");
    drive(4'h0, 4'h0, 1'b0, 8'h00, 8'h00, 1, 1, 0, "R12 halt with clear");
    drive(4'h0, 4'hF, 1'b1, 8'h0A, 8'hFF, 0, 0, 0, "R7 all ALU enabled");
    drive(4'hA, 4'h0, 1'b1, 8'h3A, 8'h0F, 0, 0, 0, "R4 near address");
    drive(4'h0, 4'h0, 1'b0, 8'h00, 8'h00, 0, 0, 1, "R10 timeout keeps PDF");
    idle("R13 hold after events");
    idle("R13 final");
    repeat (3) @(negedge clk);

    do_reset();
    drive(4'h9, 4'h9, 1'b0, 8'h00, 8'h00, 0, 0, 0, "R6 after reset");
    idle("R13 after reset");
    repeat (3) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: rd_data=%02h expected=completion", rd_data);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule